// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port that a host controls through a small word-addressed register window. Each pin can be an output, driven from a data register, or an input. The levels on the pads pass through a two-flop synchroniser and can be read back at any time. Every pin also watches its synchronised input for a trigger condition that is set per pin: low level, high level, rising edge or falling edge. An any-edge override bit per pin makes both edges count and causes the level/edge code to be ignored.

A detected condition sets a sticky status bit. Software clears a status bit by writing a one to it. The status is ANDed with a per-pin mask. The masked result drives two combined interrupt lines, one for the lower half of the pins and one for the upper half, plus one dedicated line for each of the first eight pins. An interrupt controller can therefore route low-numbered pins directly and handle the rest through the combined lines.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads zero, and `pad_o`, `pad_oe_o`, `irq_comb_o` and `irq_pin_o` are all zero.
- R2: A write at byte offset 0x00 sets the output data register, which drives `pad_o`. A write at 0x04 sets the direction register, which drives `pad_oe_o` (1 = output). Both registers read back at the same offsets.
- R3: Offset 0x08 returns the pad levels after two synchronising flops. A pad change driven between clock edges is visible on the second read cycle and not on the first. Writes to 0x08 have no effect.
- R4: Pin n takes its 2-bit trigger code from bits [2n+1:2n] of offset 0x0C for n < 16, and from bits [2(n-16)+1:2(n-16)] of offset 0x10 for n >= 16. The codes are 0 = low level, 1 = high level, 2 = rising edge, 3 = falling edge.
- R5: A level condition sets the pin's status bit on every cycle the level is present. If a clear and a detection hit the same bit in the same cycle, the bit stays set.
- R6: An edge condition sets the status bit once. The bit then stays set after the input returns, until it is cleared.
- R7: When a pin's bit in the any-edge register (offset 0x1C) is 1, both edges set its status bit and its trigger code has no effect.
- R8: The status register at 0x18 is write-one-to-clear. Bits written as 0 keep their value.
- R9: `irq_comb_o[0]` is the OR over pins 0..15 of status AND mask (mask at offset 0x14). `irq_comb_o[1]` is the same OR over pins 16..31.
- R10: `irq_pin_o[k]` is status[k] AND mask[k] for pins 0..7.
- R11: An access whose address bits [1:0] are not zero writes nothing and reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Byte address of the register access |
| we_i | input | 1 | Write strobe, sampled at the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| pad_i | input | 32 | Asynchronous pad levels |
| pad_o | output | 32 | Output data to the pads |
| pad_oe_o | output | 32 | Per-pin output enable |
| irq_comb_o | output | 2 | Combined interrupts for pins 0..15 and 16..31 |
| irq_pin_o | output | 8 | Dedicated interrupts for pins 0..7 |

## Verification
The bench uses the default parameters: 32 pins, 8 dedicated lines and a two-stage synchroniser. All 32 pins and both configuration registers are therefore exercised, including the split of trigger codes at pin 16 and the boundary between the two combined lines. Each of the four trigger codes is swept over every pin, both with and without the any-edge override, using several before/after pad patterns. A single-pin walk under a mixed per-pin configuration then isolates every pin. Expected status is computed arithmetically from the previous and new pad words, so level persistence through a clear and edge latching are both checked for every bit.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 5;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  // word index = byte offset >> 2
  typedef enum logic [2:0] {
    RI_DATA   = 3'd0,
    RI_DIR    = 3'd1,
    RI_PAD    = 3'd2,
    RI_CFG_LO = 3'd3,
    RI_CFG_HI = 3'd4,
    RI_MASK   = 3'd5,
    RI_STAT   = 3'd6,
    RI_ANYEDG = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= '0;
    else         chain_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else         chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  localparam int unsigned CFG_W   = 2 * NUM_PINS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] lvl_i,
  input  logic [CFG_W-1:0]    cfg_i,
  input  logic [NUM_PINS-1:0] any_edge_i,
  output logic [NUM_PINS-1:0] hit_o
);
  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    trig_e code;
    logic  rise, fall, hit;
    assign code = trig_e'(cfg_i[2*i +: 2]);
    assign rise = lvl_i[i] & ~prev_q[i];
    assign fall = ~lvl_i[i] & prev_q[i];
    always_comb begin
      if (any_edge_i[i]) hit = rise | fall;
      else begin
        unique case (code)
          TRIG_LOW:  hit = ~lvl_i[i];
          TRIG_HIGH: hit = lvl_i[i];
          TRIG_RISE: hit = rise;
          TRIG_FALL: hit = fall;
          default:   hit = 1'b0;
        endcase
      end
    end
    assign hit_o[i] = hit;
  end
endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned CFG_W   = 2 * NUM_PINS,
  localparam int unsigned HALF_W  = NUM_PINS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] pad_sync_i,
  input  logic [NUM_PINS-1:0] hit_i,
  output logic [NUM_PINS-1:0] data_o,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [CFG_W-1:0]    cfg_o,
  output logic [NUM_PINS-1:0] mask_o,
  output logic [NUM_PINS-1:0] any_edge_o,
  output logic [NUM_PINS-1:0] stat_o
);
  logic                aligned;
  reg_idx_e            sel;
  logic [NUM_PINS-1:0] wpins;
  logic [HALF_W-1:0]   cfg_lo_q, cfg_hi_q;
  logic [NUM_PINS-1:0] data_q, dir_q, mask_q, edge_q, stat_q, clr;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign sel     = reg_idx_e'(addr_i[ADDR_W-1:2]);
  assign wpins   = wdata_i[NUM_PINS-1:0];

  function automatic logic wr(input reg_idx_e r);
    return we_i && aligned && (sel == r);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
      edge_q   <= '0;
    end else begin
      if (wr(RI_DATA))   data_q   <= wpins;
      if (wr(RI_DIR))    dir_q    <= wpins;
      if (wr(RI_CFG_LO)) cfg_lo_q <= wdata_i[HALF_W-1:0];
      if (wr(RI_CFG_HI)) cfg_hi_q <= wdata_i[HALF_W-1:0];
      if (wr(RI_MASK))   mask_q   <= wpins;
      if (wr(RI_ANYEDG)) edge_q   <= wpins;
    end
  end

  // detection beats a same-cycle clear
  assign clr = wr(RI_STAT) ? wpins : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr) | hit_i;
  end

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      unique case (sel)
        RI_DATA:   rdata_o[NUM_PINS-1:0] = data_q;
        RI_DIR:    rdata_o[NUM_PINS-1:0] = dir_q;
        RI_PAD:    rdata_o[NUM_PINS-1:0] = pad_sync_i;
        RI_CFG_LO: rdata_o[HALF_W-1:0]   = cfg_lo_q;
        RI_CFG_HI: rdata_o[HALF_W-1:0]   = cfg_hi_q;
        RI_MASK:   rdata_o[NUM_PINS-1:0] = mask_q;
        RI_STAT:   rdata_o[NUM_PINS-1:0] = stat_q;
        RI_ANYEDG: rdata_o[NUM_PINS-1:0] = edge_q;
        default:   rdata_o = '0;
      endcase
    end
  end

  assign data_o     = data_q;
  assign dir_o      = dir_q;
  assign cfg_o      = {cfg_hi_q, cfg_lo_q};
  assign mask_o     = mask_q;
  assign any_edge_o = edge_q;
  assign stat_o     = stat_q;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned NUM_DED     = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CFG_W      = 2 * NUM_PINS,
  localparam int unsigned HALF_PINS  = NUM_PINS / 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] pad_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [1:0]          irq_comb_o,
  output logic [NUM_DED-1:0]  irq_pin_o
);
  logic [NUM_PINS-1:0] sync_w, hit_w, stat_w, mask_w, edge_w, pend_w;
  logic [CFG_W-1:0]    cfg_w;

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (sync_w)
  );

  gpio_trig_detect #(.NUM_PINS(NUM_PINS)) u_det (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_i     (sync_w),
    .cfg_i     (cfg_w),
    .any_edge_i(edge_w),
    .hit_o     (hit_w)
  );

  gpio_reg_bank #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .we_i      (we_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .pad_sync_i(sync_w),
    .hit_i     (hit_w),
    .data_o    (pad_o),
    .dir_o     (pad_oe_o),
    .cfg_o     (cfg_w),
    .mask_o    (mask_w),
    .any_edge_o(edge_w),
    .stat_o    (stat_w)
  );

  assign pend_w        = stat_w & mask_w;
  assign irq_comb_o[0] = |pend_w[HALF_PINS-1:0];
  assign irq_comb_o[1] = |pend_w[NUM_PINS-1:HALF_PINS];

  for (genvar k = 0; k < NUM_DED; k++) begin : g_ded
    assign irq_pin_o[k] = pend_w[k];
  end
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
  parameter int unsigned N  = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned ND = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [4:0]    addr_i,
  input logic          we_i,
  input logic [DW-1:0] wdata_i,
  input logic [N-1:0]  stat,
  input logic [N-1:0]  hit,
  input logic [N-1:0]  mask,
  input logic [N-1:0]  pad_o,
  input logic [N-1:0]  pad_oe_o,
  input logic [1:0]    irq_comb_o,
  input logic [ND-1:0] irq_pin_o
);
  logic stat_wr;
  assign stat_wr = we_i && (addr_i == 5'h18);

  AST_DATA_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 5'h00) |=> pad_o == $past(wdata_i[N-1:0])); // R2
  AST_DIR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 5'h04) |=> pad_oe_o == $past(wdata_i[N-1:0])); // R2
  AST_STAT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_wr |=> ($past(stat) & ~stat) == '0); // R6
  AST_STAT_SET_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (stat & ~$past(stat) & ~$past(hit)) == '0); // R5
  AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr |=> (stat & $past(wdata_i[N-1:0]) & ~$past(hit)) == '0); // R8
  AST_HIT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> ($past(hit) & ~stat) == '0); // R5
  AST_PIN_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_pin_o & ~mask[ND-1:0]) == '0); // R10
  AST_COMB_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat & mask) == '0) |-> (irq_comb_o == 2'b00)); // R9
endmodule

bind gpio_irq_port gpio_irq_chk #(.N(NUM_PINS), .DW(DATA_W), .ND(NUM_DED)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .we_i      (we_i),
  .wdata_i   (wdata_i),
  .stat      (stat_w),
  .hit       (hit_w),
  .mask      (mask_w),
  .pad_o     (pad_o),
  .pad_oe_o  (pad_oe_o),
  .irq_comb_o(irq_comb_o),
  .irq_pin_o (irq_pin_o)
);

// File: tb/sim_gpio_irq_port.sv
`timescale 1ns/1ps
module sim_gpio_irq_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pads = '0;
  logic [31:0] pad_o, pad_oe;
  logic [1:0]  irq_comb;
  logic [7:0]  irq_pin;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  gpio_irq_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pad_i(pads), .pad_o(pad_o), .pad_oe_o(pad_oe),
    .irq_comb_o(irq_comb), .irq_pin_o(irq_pin)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic logic [31:0] expect_stat(input logic [31:0] lo, input logic [31:0] hi,
                                               input logic [31:0] ae, input logic [31:0] a,
                                               input logic [31:0] b);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) begin
      logic [1:0] c = (i < 16) ? lo[2*i +: 2] : hi[2*(i-16) +: 2];
      if (ae[i]) r[i] = a[i] ^ b[i];
      else case (c)
        2'd0: r[i] = ~a[i] | ~b[i];
        2'd1: r[i] = a[i] | b[i];
        2'd2: r[i] = ~a[i] & b[i];
        default: r[i] = a[i] & ~b[i];
      endcase
    end
    return r;
  endfunction

  // settle on a, clear all, move to b, compare status and irq lines
  task automatic run_case(input string req, input logic [31:0] lo, input logic [31:0] hi,
                          input logic [31:0] ae, input logic [31:0] msk,
                          input logic [31:0] a, input logic [31:0] b);
    logic [31:0] st, ex, pend;
    wr(5'h0C, lo); wr(5'h10, hi); wr(5'h1C, ae); wr(5'h14, msk);
    pads = a;
    wait_n(4);
    wr(5'h18, 32'hFFFF_FFFF);
    pads = b;
    wait_n(4);
    rd(5'h18, st);
    ex = expect_stat(lo, hi, ae, a, b);
    pend = ex & msk;
    check(req, st, ex);
    check("R9 combined", {30'd0, irq_comb}, {30'd0, |pend[31:16], |pend[15:0]});
    check("R10 dedicated", {24'd0, irq_pin}, {24'd0, pend[7:0]});
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] pa [4];
    logic [31:0] pb [4];
    pa[0] = 32'h0000_0000; pb[0] = 32'hFFFF_FFFF;
    pa[1] = 32'hFFFF_FFFF; pb[1] = 32'h0000_0000;
    pa[2] = 32'h0000_FFFF; pb[2] = 32'hA5A5_C33C;
    pa[3] = 32'h1234_5678; pb[3] = 32'h8765_4321;

    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(5'h00, v); check("R1 data", v, 0);
    rd(5'h04, v); check("R1 dir", v, 0);
    rd(5'h0C, v); check("R1 cfg lo", v, 0);
    rd(5'h10, v); check("R1 cfg hi", v, 0);
    rd(5'h14, v); check("R1 mask", v, 0);
    rd(5'h1C, v); check("R1 anyedge", v, 0);
    check("R1 pad_o", pad_o, 0);
    check("R1 pad_oe", pad_oe, 0);
    check("R1 irq", {22'd0, irq_comb, irq_pin}, 0);

    // R2 data and direction
    wr(5'h00, 32'hA5A5_0FF0);
    wr(5'h04, 32'hFFFF_0000);
    check("R2 pad_o", pad_o, 32'hA5A5_0FF0);
    check("R2 pad_oe", pad_oe, 32'hFFFF_0000);
    rd(5'h00, v); check("R2 data rb", v, 32'hA5A5_0FF0);
    rd(5'h04, v); check("R2 dir rb", v, 32'hFFFF_0000);

    // R11 misaligned access ignored
    wr(5'h05, 32'h1234_5678);
    rd(5'h04, v); check("R11 dir kept", v, 32'hFFFF_0000);
    rd(5'h05, v); check("R11 read zero", v, 0);

    // R3 synchroniser depth and read-only pad status
    @(negedge clk);
    pads = 32'hC0DE_5AA5;
    @(negedge clk); rd(5'h08, v); check("R3 one cycle", v, 0);
    @(negedge clk); rd(5'h08, v); check("R3 two cycles", v, 32'hC0DE_5AA5);
    wr(5'h08, 32'h0);
    rd(5'h08, v); check("R3 write ignored", v, 32'hC0DE_5AA5);

    // R4..R7 uniform codes, with and without any-edge override
    for (int m = 0; m < 4; m++) begin
      for (int e = 0; e < 2; e++) begin
        for (int p = 0; p < 4; p++) begin
          logic [31:0] cw = {16{m[1:0]}};
          string tag = e ? "R7 anyedge" : (m < 2 ? "R5 level" : "R6 edge");
          run_case(tag, cw, cw, e ? 32'hFFFF_FFFF : 32'h0, 32'h5AF0_0FF3, pa[p], pb[p]);
        end
      end
    end

    // R4 mixed per-pin codes, single-pin walk across both config words
    for (int k = 0; k < 32; k++) begin
      run_case("R4 walk up", 32'hE4E4_E4E4, 32'h1B1B_1B1B, 32'h0081_0000, 32'hFFFF_FFFF,
               32'h0, 32'h1 << k);
      run_case("R4 walk down", 32'hE4E4_E4E4, 32'h1B1B_1B1B, 32'h0081_0000, 32'h8000_00FF,
               32'hFFFF_FFFF, ~(32'h1 << k));
    end

    // R8 write-one-to-clear and R6 latching
    wr(5'h0C, 32'hAAAA_AAAA); wr(5'h10, 32'hAAAA_AAAA); wr(5'h1C, 32'h0);
    pads = 32'h0; wait_n(4);
    wr(5'h18, 32'hFFFF_FFFF);
    pads = 32'hFFFF_FFFF; wait_n(4);
    pads = 32'h0; wait_n(4);
    rd(5'h18, v); check("R6 latched", v, 32'hFFFF_FFFF);
    wr(5'h18, 32'h0F0F_00FF);
    rd(5'h18, v); check("R8 partial clear", v, 32'hF0F0_FF00);
    wr(5'h18, 32'h0);
    rd(5'h18, v); check("R8 zero write", v, 32'hF0F0_FF00);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule